// File: doc/BRIEF.md
# Masked GPIO Port Register Bank

This block is a 32-pin general-purpose I/O port behind a simple synchronous register bus. The bus has an address, write data, a write enable, a read enable and a registered read data output. Inside are one output register, one direction register and one mask register. Software reaches the same pin state through several views. The first is a plain port view. The second is a masked port view, in which the mask hides selected pins. Three write strobes set, clear or invert any group of output bits. Each pin also has its own byte-wide and word-wide alias, so it can be read or written on its own.

Pin inputs pass through a two-flop synchronizer before any read can see them. A port read returns the synchronized input for pins set as inputs and the output register for pins set as outputs. The output register drives `gpio_o` and the direction register drives `gpio_oe_o`. Software can use the mask to update a subset of pins with a single write, leaving the other pins untouched. Mutual exclusion on the mask is left to software.

Address map (byte addresses): byte alias of pin p at p. Word alias of pin p at 0x400 + 4p. Direction at 0x800, mask at 0x804, port at 0x808, masked port at 0x80C, set at 0x810, clear at 0x814, toggle at 0x818.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the following are all zero: the output, direction and mask registers, `gpio_o`, `gpio_oe_o` and `rdata_o`. Reads of direction, mask and port then return 0 while `gpio_i` is 0.
- R2: A write to the port register (0x808) loads the output register, and `gpio_o` shows it after that clock edge. A read issued with `re_i` at one edge places its data on `rdata_o` after that edge. `rdata_o` is 0 in any cycle that follows an edge where `re_i` was low. For each pin, a port read returns the output bit if the direction bit is 1 and the synchronized input bit if it is 0.
- R3: A masked port read (0x80C) returns the port read value with every bit whose mask bit is 1 forced to 0.
- R4: A masked port write changes only the output bits whose mask bit is 0. Output bits whose mask bit is 1 keep their value.
- R5: With the mask all zeros, masked port reads and writes give the same results as port reads and writes.
- R6: A write to the set register (0x810) drives high each output bit written as 1. It leaves the other bits unchanged.
- R7: A write to the clear register (0x814) drives low each output bit written as 1. It leaves the other bits unchanged.
- R8: A write to the toggle register (0x818) inverts each output bit written as 1. It leaves the other bits unchanged.
- R9: A byte alias read returns the port view of that pin in bit 0, with all other bits 0. On a byte alias write, the pin's output bit is set if `wdata_i[7:0]` is nonzero and cleared if it is zero. Bits above 7 are ignored.
- R10: A word alias read returns all ones if the pin's port view is 1 and all zeros if it is 0. On a word alias write, the pin's output bit is set if the 32-bit write data is nonzero and cleared otherwise.
- R11: Suppose `gpio_i` changes before clock edge A. Port reads sampled at edges A and A+1 still return the old value. Reads sampled at edge A+2 and later return the new value.
- R12: `gpio_oe_o` equals the direction register (0x800, 1 = drive). It changes only after a write to that address, and it reads back unchanged.
- R13: Writes to unmapped addresses change no state. Reads of unmapped addresses and of the set, clear and toggle registers return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Registered read data |
| gpio_i | input | 32 | Raw pin inputs |
| gpio_o | output | 32 | Pin output values |
| gpio_oe_o | output | 32 | Pin output enables |

## Verification
Writes are due at `gpio_o` and `gpio_oe_o` one edge after the write. The bench therefore compares the pins at the falling edge that follows the write cycle. Read data is due one edge after `re_i` is sampled. The driver pushes each expected word as it raises `re_i`, and the monitor pops it at the next falling edge if a read was sampled at the edge before. Input changes are due three read-sample edges later because of the synchronizer. The bench issues back-to-back reads across that window and expects the old value twice before the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_BYTE,
    ACC_WORD,
    ACC_DIR,
    ACC_MASK,
    ACC_PORT,
    ACC_MPORT,
    ACC_SET,
    ACC_CLR,
    ACC_TGL
  } acc_e;

  // register offsets from the register block base
  localparam int unsigned OFS_DIR   = 'h00;
  localparam int unsigned OFS_MASK  = 'h04;
  localparam int unsigned OFS_PORT  = 'h08;
  localparam int unsigned OFS_MPORT = 'h0C;
  localparam int unsigned OFS_SET   = 'h10;
  localparam int unsigned OFS_CLR   = 'h14;
  localparam int unsigned OFS_TGL   = 'h18;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned N_PINS    = 32,
  parameter int unsigned PIN_W     = 5,
  parameter int unsigned WORD_BASE = 'h400,
  parameter int unsigned REG_BASE  = 'h800
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              kind_o,
  output logic [PIN_W-1:0]  pin_o
);

  localparam logic [ADDR_W-1:0] BYTE_END = ADDR_W'(N_PINS);
  localparam logic [ADDR_W-1:0] WORD_BEG = ADDR_W'(WORD_BASE);
  localparam logic [ADDR_W-1:0] WORD_END = ADDR_W'(WORD_BASE + 4 * N_PINS);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(REG_BASE + OFS_DIR);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(REG_BASE + OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PORT   = ADDR_W'(REG_BASE + OFS_PORT);
  localparam logic [ADDR_W-1:0] A_MPORT  = ADDR_W'(REG_BASE + OFS_MPORT);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(REG_BASE + OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(REG_BASE + OFS_CLR);
  localparam logic [ADDR_W-1:0] A_TGL    = ADDR_W'(REG_BASE + OFS_TGL);

  logic [ADDR_W-1:0] word_off;
  logic              byte_hit, word_hit;

  assign word_off = addr_i - WORD_BEG;
  assign byte_hit = addr_i < BYTE_END;
  assign word_hit = (addr_i >= WORD_BEG) && (addr_i < WORD_END) && (addr_i[1:0] == 2'b00);

  always_comb begin
    kind_o = ACC_NONE;
    pin_o  = '0;
    if (byte_hit) begin
      kind_o = ACC_BYTE;
      pin_o  = addr_i[PIN_W-1:0];
    end else if (word_hit) begin
      kind_o = ACC_WORD;
      pin_o  = word_off[PIN_W+1:2];
    end else begin
      unique case (addr_i)
        A_DIR:   kind_o = ACC_DIR;
        A_MASK:  kind_o = ACC_MASK;
        A_PORT:  kind_o = ACC_PORT;
        A_MPORT: kind_o = ACC_MPORT;
        A_SET:   kind_o = ACC_SET;
        A_CLR:   kind_o = ACC_CLR;
        A_TGL:   kind_o = ACC_TGL;
        default: kind_o = ACC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_out_next.sv
module gpio_out_next
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIN_W  = 5
) (
  input  logic              we_i,
  input  acc_e              kind_i,
  input  logic [PIN_W-1:0]  pin_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_PINS-1:0] out_i,
  input  logic [N_PINS-1:0] mask_i,
  output logic [N_PINS-1:0] out_nxt_o
);

  logic [N_PINS-1:0] wd;
  logic              alias_wr, strobe_wr, port_wr;

  assign wd        = wdata_i[N_PINS-1:0];
  assign alias_wr  = we_i && (kind_i inside {ACC_BYTE, ACC_WORD});
  assign strobe_wr = we_i && (kind_i inside {ACC_SET, ACC_CLR, ACC_TGL});
  assign port_wr   = we_i && (kind_i inside {ACC_PORT, ACC_MPORT});

  // fixed priority: alias, then strobes, then port views
  always_comb begin
    out_nxt_o = out_i;
    if (alias_wr) begin
      if (kind_i == ACC_BYTE) out_nxt_o[pin_i] = |wdata_i[7:0];
      else                    out_nxt_o[pin_i] = |wdata_i;
    end else if (strobe_wr) begin
      case (kind_i)
        ACC_SET: out_nxt_o = out_i | wd;
        ACC_CLR: out_nxt_o = out_i & ~wd;
        default: out_nxt_o = out_i ^ wd;
      endcase
    end else if (port_wr) begin
      if (kind_i == ACC_PORT) out_nxt_o = wd;
      else                    out_nxt_o = (out_i & mask_i) | (wd & ~mask_i);
    end
  end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SYNC_LEN  = 2,
  parameter int unsigned WORD_BASE = 'h400,
  parameter int unsigned REG_BASE  = 'h800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] gpio_i,
  output logic [N_PINS-1:0] gpio_o,
  output logic [N_PINS-1:0] gpio_oe_o
);

  localparam int unsigned PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1;

  acc_e              acc_kind;
  logic [PIN_W-1:0]  acc_pin;
  logic [N_PINS-1:0] out_q, out_nxt, dir_q, mask_q, in_sync, port_view;
  logic [DATA_W-1:0] rd_nxt, rdata_q;

  gpio_addr_dec #(
    .ADDR_W   (ADDR_W),
    .N_PINS   (N_PINS),
    .PIN_W    (PIN_W),
    .WORD_BASE(WORD_BASE),
    .REG_BASE (REG_BASE)
  ) u_dec (
    .addr_i(addr_i),
    .kind_o(acc_kind),
    .pin_o (acc_pin)
  );

  gpio_sync #(
    .WIDTH (N_PINS),
    .STAGES(SYNC_LEN)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (in_sync)
  );

  gpio_out_next #(
    .N_PINS(N_PINS),
    .DATA_W(DATA_W),
    .PIN_W (PIN_W)
  ) u_next (
    .we_i     (we_i),
    .kind_i   (acc_kind),
    .pin_i    (acc_pin),
    .wdata_i  (wdata_i),
    .out_i    (out_q),
    .mask_i   (mask_q),
    .out_nxt_o(out_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      out_q <= out_nxt;
      if (we_i && acc_kind == ACC_DIR)  dir_q  <= wdata_i[N_PINS-1:0];
      if (we_i && acc_kind == ACC_MASK) mask_q <= wdata_i[N_PINS-1:0];
    end
  end

  assign port_view = (dir_q & out_q) | (~dir_q & in_sync);

  always_comb begin
    case (acc_kind)
      ACC_BYTE:  rd_nxt = DATA_W'(port_view[acc_pin]);
      ACC_WORD:  rd_nxt = {DATA_W{port_view[acc_pin]}};
      ACC_DIR:   rd_nxt = DATA_W'(dir_q);
      ACC_MASK:  rd_nxt = DATA_W'(mask_q);
      ACC_PORT:  rd_nxt = DATA_W'(port_view);
      ACC_MPORT: rd_nxt = DATA_W'(port_view & ~mask_q);
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_nxt;
    else           rdata_q <= '0;
  end

  assign rdata_o   = rdata_q;
  assign gpio_o    = out_q;
  assign gpio_oe_o = dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_PINS-1:0] gpio_o,
  input logic [N_PINS-1:0] gpio_oe_o,
  input acc_e              kind_i,
  input logic [N_PINS-1:0] mask_i
);

  assert_idle_read_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_o == '0);

  assert_mport_read_hidden_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && kind_i == ACC_MPORT) |=> (rdata_o[N_PINS-1:0] & $past(mask_i)) == '0);

  assert_mport_write_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == ACC_MPORT) |=> (gpio_o & $past(mask_i)) == ($past(gpio_o) & $past(mask_i)));

  assert_set_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == ACC_SET) |=>
      gpio_o == ($past(gpio_o) | $past(wdata_i[N_PINS-1:0])));

  assert_clear_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == ACC_CLR) |=>
      gpio_o == ($past(gpio_o) & ~$past(wdata_i[N_PINS-1:0])));

  assert_toggle_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == ACC_TGL) |=>
      gpio_o == ($past(gpio_o) ^ $past(wdata_i[N_PINS-1:0])));

  assert_oe_only_on_dir_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && kind_i == ACC_DIR) |=> $stable(gpio_oe_o));

  assert_unmapped_write_no_effect_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == ACC_NONE) |=> $stable(gpio_o) && $stable(gpio_oe_o));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .N_PINS(N_PINS),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .re_i     (re_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .gpio_o   (gpio_o),
  .gpio_oe_o(gpio_oe_o),
  .kind_i   (acc_kind),
  .mask_i   (mask_q)
);

// File: tb/gpio_mask_port_tb.sv
`timescale 1ns/1ps
module gpio_mask_port_tb;

  localparam logic [11:0] A_DIR = 12'h800, A_MASK = 12'h804, A_PORT = 12'h808,
                          A_MPORT = 12'h80C, A_SET = 12'h810, A_CLR = 12'h814,
                          A_TGL = 12'h818, A_WORD = 12'h400;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, gpio_in = '0, gpio_out, gpio_oe;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_out = '0, m_dir = '0, m_mask = '0, m_in = '0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];
  logic  rd_pend = 1'b0;

  always #10 clk = ~clk;

  gpio_mask_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata),
    .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe_o(gpio_oe)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pv();
    return (m_dir & m_out) | (~m_dir & m_in);
  endfunction

  // scoreboard monitor
  always @(posedge clk) rd_pend <= re && rst_n;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) chk(rdata, 32'hx, "SB_EMPTY");
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(rdata, it.exp, it.req);
      end
    end else if (rst_n) begin
      n_tests++;
      if (rdata !== '0) begin
        n_fail++;
        $display("FAIL R2: idle rdata actual %h expected 0", rdata);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    case (a)
      A_DIR:   m_dir = d;
      A_MASK:  m_mask = d;
      A_PORT:  m_out = d;
      A_MPORT: m_out = (m_out & m_mask) | (d & ~m_mask);
      A_SET:   m_out = m_out | d;
      A_CLR:   m_out = m_out & ~d;
      A_TGL:   m_out = m_out ^ d;
      default: begin
        if (a < 12'd32) m_out[a[4:0]] = |d[7:0];
        else if (a >= A_WORD && a < A_WORD + 12'd128 && a[1:0] == 2'b00)
          m_out[5'((a - A_WORD) >> 2)] = |d;
      end
    endcase
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    item_t it;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL WATCHDOG: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk(gpio_out, 32'h0, "R1 gpio_o");
    chk(gpio_oe, 32'h0, "R1 gpio_oe_o");
    chk(rdata, 32'h0, "R1 rdata_o");
    rst_n = 1'b1;
    idle(1);
    rd(A_DIR, 32'h0, "R1 dir");
    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_PORT, 32'h0, "R1 port");

    // inputs seen through port view
    gpio_in = 32'hA5A5_0F0F; m_in = gpio_in;
    idle(3);
    rd(A_PORT, 32'hA5A5_0F0F, "R2 input read");

    wr(A_DIR, 32'hFFFF_0000);
    chk(gpio_oe, 32'hFFFF_0000, "R12 oe");
    wr(A_PORT, 32'h1234_5678);
    chk(gpio_out, 32'h1234_5678, "R2 port write");
    rd(A_PORT, pv(), "R2 mixed read");
    rd(A_DIR, 32'hFFFF_0000, "R12 dir readback");

    wr(A_SET, 32'h0000_00F0);
    chk(gpio_out, m_out, "R6 set");
    wr(A_CLR, 32'h1200_0008);
    chk(gpio_out, m_out, "R7 clear");
    wr(A_TGL, 32'hFFFF_FFFF);
    chk(gpio_out, m_out, "R8 toggle all");
    wr(A_TGL, 32'h0000_0000);
    chk(gpio_out, m_out, "R8 toggle none");

    // mask all zeros
    wr(A_MPORT, 32'hDEAD_BEEF);
    chk(gpio_out, 32'hDEAD_BEEF, "R5 mport write");
    rd(A_MPORT, pv(), "R5 mport read");
    rd(A_PORT, pv(), "R5 port read");

    wr(A_MASK, 32'hFF00_FF00);
    rd(A_MASK, 32'hFF00_FF00, "R3 mask readback");
    wr(A_MPORT, 32'h1111_1111);
    chk(gpio_out, 32'hDE11_BE11, "R4 mport keeps masked");
    rd(A_MPORT, pv() & ~m_mask, "R3 mport read hidden");
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MPORT, 32'h0, "R3 all hidden");
    wr(A_MPORT, 32'h0);
    chk(gpio_out, 32'hDE11_BE11, "R4 all masked write");

    // byte aliases
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(12'd3, 32'h0000_0080);
    chk(gpio_out, m_out, "R9 byte set");
    wr(12'd4, 32'h0000_0000);
    chk(gpio_out, m_out, "R9 byte clear");
    wr(12'd0, 32'h0000_0100);
    chk(gpio_out[0], 1'b0, "R9 upper bits ignored");
    rd(12'd3, 32'h1, "R9 byte read one");
    rd(12'd4, 32'h0, "R9 byte read zero");

    // word aliases
    wr(A_WORD + 12'd124, 32'h8000_0000);
    chk(gpio_out[31], 1'b1, "R10 word set");
    wr(A_WORD + 12'd8, 32'h0);
    chk(gpio_out, m_out, "R10 word clear");
    rd(A_WORD + 12'd124, 32'hFFFF_FFFF, "R10 word read ones");
    rd(A_WORD + 12'd8, 32'h0, "R10 word read zeros");

    // unmapped and write-only
    wr(12'h7FC, 32'hFFFF_FFFF);
    wr(12'h81C, 32'hFFFF_FFFF);
    chk(gpio_out, m_out, "R13 unmapped write out");
    chk(gpio_oe, m_dir, "R13 unmapped write oe");
    rd(12'h7FC, 32'h0, "R13 unmapped read");
    rd(A_SET, 32'h0, "R13 set read");
    rd(A_CLR, 32'h0, "R13 clear read");
    rd(A_TGL, 32'h0, "R13 toggle read");

    // synchronizer latency, inputs
    wr(A_DIR, 32'h0);
    chk(gpio_oe, 32'h0, "R12 oe cleared");
    gpio_in = 32'h3C3C_C3C3;
    rd(A_PORT, 32'hA5A5_0F0F, "R11 edge A old");
    rd(A_PORT, 32'hA5A5_0F0F, "R11 edge A+1 old");
    rd(A_PORT, 32'h3C3C_C3C3, "R11 edge A+2 new");
    m_in = gpio_in;
    rd(12'd2, {31'h0, m_in[2]}, "R9 byte input pin");

    idle(2);
    chk(sb_q.size(), 0, "SB drained");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule